// File: doc/BRIEF.md
# Programmable Trigger Condition Evaluator

This block decides whether an event is worth keeping. It looks at multiplicity fold flags and at front-panel logic levels, and it raises a trigger request when a programmable sum of products of those conditions becomes true. Each sumbus gives several fold flags. Flag `l` of sumbus `s` means the fold on that sumbus is at or above its l-th programmed level. The front-panel logic inputs are plain levels. One fold flag per sumbus, and the first few logic inputs, also pass through a retiming stage. A retiming stage turns a rising edge into a pulse with a programmable delay and a programmable width, so that slow or early signals can be lined up with the others.

All direct and retimed conditions form one condition vector. Every product term has a mask that names the conditions it needs, and the term fires when all of those conditions are high. An OR-select register picks the terms that feed the final OR. A rising edge of the OR result gives a one-cycle trigger request. The registered term results are also brought out so that they can be monitored. Software loads the masks, the OR selection and the retiming settings through a simple address/data write port.

Top module: `trig_eval`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trig_req` and `term_hit` are all zero. Reset clears every mask, the OR selection and every retiming setting.
- R2: The condition vector is laid out as follows. Bit `s*4+l` (0..15) is `fold_in[s*4+l]`. Bits 16..19 are the retimed copies of `fold_in[s*4]` for s = 0..3. Bits 20..27 are `logic_in[0..7]`. Bits 28..31 are the retimed copies of `logic_in[0..3]`.
- R3: `term_hit[t]` is high one clock edge after every condition bit selected by mask t is high. It is low if any selected bit is low.
- R4: A term whose mask is all zero never fires, whatever the inputs are.
- R5: `trig_req` can only come from terms whose bit is set in the OR-select register. A term that is not selected still shows on `term_hit`.
- R6: `trig_req` is high for exactly one cycle when the selected OR rises. An OR that stays high does not trigger again.
- R7: While `enable` is low, `trig_req` is low.
- R8: Suppose a retiming stage has delay D and width W ≥ 1, and its source is first seen high at clock edge E. Then the term that uses its output is high after edges E+D+1 through E+D+W.
- R9: A retiming stage ignores rising edges while it is delaying or pulsing. A stage with width 0 never produces a pulse.
- R10: The write port decodes addresses as follows. Address t (0..3) loads the mask of term t. Address 4 loads the OR selection in bits [3:0]. Address 5+k (k = 0..7) loads retiming stage k, with the delay in bits [7:0] and the width in bits [15:8]. Stages 0..3 serve the sumbuses and stages 4..7 serve logic inputs 0..3. A write takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global trigger enable |
| fold_in | input | 16 | Fold flags, 4 per sumbus, index s*4+l |
| logic_in | input | 8 | Front-panel logic levels |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| trig_req | output | 1 | One-cycle trigger request |
| term_hit | output | 4 | Registered product-term results |

## Verification
A direct condition shows on `term_hit` one edge after it is applied, and `trig_req` rises together with it. A retimed condition reaches `term_hit` D+1 edges after its source is first seen, and it stays there for W edges. The bench drives inputs on the falling edge and then samples on the following falling edges. It counts edges from the edge that first sees the stimulus and compares each sample with the window worked out from D and W. The sweep covers every direct bit of the condition vector, and all eight retiming stages over several delay and width settings.

// File: rtl/trig_pkg.sv
package trig_pkg;
   typedef enum logic [1:0] {
      AL_IDLE = 2'd0,
      AL_WAIT = 2'd1,
      AL_HOLD = 2'd2
   } align_state_t;
endpackage

// File: rtl/trig_align.sv
module trig_align #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             din,
   input  logic [CNT_W-1:0] dly,
   input  logic [CNT_W-1:0] wid,
   output logic             dout
);
   import trig_pkg::*;

   align_state_t     st_q;
   logic [CNT_W-1:0] cnt_q;
   logic             din_q;
   logic             rise;

   assign rise = din & ~din_q;
   assign dout = (st_q == AL_HOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= AL_IDLE;
         cnt_q <= '0;
         din_q <= 1'b0;
      end else begin
         din_q <= din;
         unique case (st_q)
            AL_IDLE: begin
               if (rise && wid != '0) begin
                  if (dly == '0) begin
                     st_q  <= AL_HOLD;
                     cnt_q <= wid - 1'b1;
                  end else begin
                     st_q  <= AL_WAIT;
                     cnt_q <= dly - 1'b1;
                  end
               end
            end
            AL_WAIT: begin
               if (cnt_q == '0) begin
                  if (wid == '0) begin
                     st_q <= AL_IDLE;
                  end else begin
                     st_q  <= AL_HOLD;
                     cnt_q <= wid - 1'b1;
                  end
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            AL_HOLD: begin
               if (cnt_q == '0) st_q <= AL_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            default: st_q <= AL_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/trig_term.sv
module trig_term #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cond,
   input  logic [CW-1:0] mask,
   output logic          hit
);
   logic all_met;
   logic armed;

   assign all_met = &(cond | ~mask);
   assign armed   = |mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit <= 1'b0;
      else        hit <= armed & all_met;
   end
endmodule

// File: rtl/trig_eval.sv
module trig_eval #(
   parameter int NSUM     = 4,
   parameter int NLVL     = 4,
   parameter int NLOGIC   = 8,
   parameter int NALN_LOG = 4,
   parameter int NTERM    = 4,
   parameter int CNT_W    = 8,
   parameter int AW       = 4,
   parameter int DATA_W   = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   enable,
   input  logic [NSUM*NLVL-1:0]   fold_in,
   input  logic [NLOGIC-1:0]      logic_in,
   input  logic                   cfg_we,
   input  logic [AW-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]      cfg_wdata,
   output logic                   trig_req,
   output logic [NTERM-1:0]       term_hit
);
   localparam int NFOLD   = NSUM * NLVL;
   localparam int NA      = NSUM + NALN_LOG;
   localparam int CW      = NFOLD + NSUM + NLOGIC + NALN_LOG;
   localparam int OR_ADDR = NTERM;
   localparam int AL_BASE = NTERM + 1;

   if (CW > DATA_W) begin : g_chk_cw
      $error("condition vector wider than write data");
   end
   if (NALN_LOG > NLOGIC) begin : g_chk_aln
      $error("more retimed logic inputs than logic inputs");
   end
   if (AL_BASE + NA > (1 << AW)) begin : g_chk_addr
      $error("address space too small for register map");
   end
   if (2 * CNT_W > DATA_W) begin : g_chk_cnt
      $error("retiming fields do not fit write data");
   end
   if (NTERM > DATA_W) begin : g_chk_term
      $error("too many terms for OR-select register");
   end

   logic [NTERM-1:0][CW-1:0] mask_q;
   logic [NTERM-1:0]         or_sel_q;
   logic [NA-1:0][CNT_W-1:0] dly_q;
   logic [NA-1:0][CNT_W-1:0] wid_q;
   logic [NA-1:0]            aln_src;
   logic [NA-1:0]            aln_out;
   logic [CW-1:0]            cond;
   logic                     or_now;
   logic                     or_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         or_sel_q <= '0;
         dly_q    <= '0;
         wid_q    <= '0;
      end else if (cfg_we) begin
         for (int t = 0; t < NTERM; t++) begin
            if (int'(cfg_addr) == t) mask_q[t] <= cfg_wdata[CW-1:0];
         end
         if (int'(cfg_addr) == OR_ADDR) or_sel_q <= cfg_wdata[NTERM-1:0];
         for (int k = 0; k < NA; k++) begin
            if (int'(cfg_addr) == AL_BASE + k) begin
               dly_q[k] <= cfg_wdata[CNT_W-1:0];
               wid_q[k] <= cfg_wdata[2*CNT_W-1:CNT_W];
            end
         end
      end
   end

   for (genvar s = 0; s < NSUM; s++) begin : g_fold_src
      assign aln_src[s] = fold_in[s*NLVL];
   end
   for (genvar g = 0; g < NALN_LOG; g++) begin : g_log_src
      assign aln_src[NSUM+g] = logic_in[g];
   end

   for (genvar k = 0; k < NA; k++) begin : g_align
      trig_align #(.CNT_W(CNT_W)) i_align (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (aln_src[k]),
         .dly  (dly_q[k]),
         .wid  (wid_q[k]),
         .dout (aln_out[k])
      );
   end

   assign cond = {aln_out[NA-1:NSUM], logic_in, aln_out[NSUM-1:0], fold_in};

   for (genvar t = 0; t < NTERM; t++) begin : g_term
      trig_term #(.CW(CW)) i_term (
         .clk  (clk),
         .rst_n(rst_n),
         .cond (cond),
         .mask (mask_q[t]),
         .hit  (term_hit[t])
      );
   end

   assign or_now = |(term_hit & or_sel_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) or_prev_q <= 1'b0;
      else        or_prev_q <= or_now;
   end

   assign trig_req = enable & or_now & ~or_prev_q;
endmodule

// File: rtl/trig_eval_chk.sv
module trig_eval_chk #(
   parameter int NTERM = 4,
   parameter int CW    = 32
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   enable,
   input logic                   trig_req,
   input logic [NTERM-1:0]       term_hit,
   input logic [NTERM-1:0]       or_sel,
   input logic [NTERM-1:0][CW-1:0] mask
);
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!trig_req && term_hit == '0));

   p_term_needs_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(mask[0] == '0) |-> !term_hit[0]);

   p_trig_from_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trig_req |-> (|(term_hit & or_sel)));

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_req |=> !trig_req);

   p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !trig_req);
endmodule

bind trig_eval trig_eval_chk #(.NTERM(NTERM), .CW(CW)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .enable  (enable),
   .trig_req(trig_req),
   .term_hit(term_hit),
   .or_sel  (or_sel_q),
   .mask    (mask_q)
);

// File: tb/test_trig_eval.sv
module test_trig_eval;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b1;
   logic [15:0] fold_in = '0;
   logic [7:0]  logic_in = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        trig_req;
   logic [3:0]  term_hit;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   trig_eval i_trig_eval (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fold_in(fold_in),
      .logic_in(logic_in), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .trig_req(trig_req), .term_hit(term_hit)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired: actual=%0d cycles expected=<150000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input logic act, input logic exp, input string req);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] data);
      cfg_we = 1'b1;
      cfg_addr = 4'(addr);
      cfg_wdata = data;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic clr_in();
      fold_in = '0;
      logic_in = '0;
   endtask

   // set direct condition bit b (0..15 fold, 20..27 logic)
   task automatic set_direct(input int b, input logic v);
      if (b < 16) fold_in[b] = v;
      else        logic_in[b-20] = v;
   endtask

   // sweep one retiming stage: source k, delay d, width w; second_rise at j=2 if busy
   task automatic run_align(input int k, input int d, input int w, input bit busy);
      int cb;
      bit exp;
      cb = (k < 4) ? 16 + k : 28 + (k - 4);
      wr(5 + k, {16'd0, 8'(w), 8'(d)});
      wr(0, 32'd1 << cb);
      wr(4, 32'd1);
      clr_in();
      step(); step();
      if (k < 4) fold_in[k*4] = 1'b1; else logic_in[k-4] = 1'b1;
      for (int j = 0; j <= d + w + 3; j++) begin
         step();
         if (busy && j == 1) begin
            if (k < 4) fold_in[k*4] = 1'b1; else logic_in[k-4] = 1'b1;
         end else begin
            clr_in();
         end
         exp = (w > 0) && (j >= d + 1) && (j <= d + w);
         if (busy) chk(term_hit[0], exp, $sformatf("R9 busy stage%0d j=%0d", k, j));
         else      chk(term_hit[0], exp, $sformatf("R8 stage%0d d=%0d w=%0d j=%0d", k, d, w, j));
         if (!busy && w > 0 && j == d + 1) chk(trig_req, 1'b1, "R8 trig at window start");
      end
      wr(5 + k, 32'd0);
   endtask

   initial begin
      // R1 reset state
      #1;
      chk(trig_req, 1'b0, "R1 trig in reset");
      chk(term_hit[0], 1'b0, "R1 term in reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      fold_in = '1;
      logic_in = '1;
      step();
      chk(trig_req, 1'b0, "R1 trig after reset, masks cleared");
      chk(term_hit[0] | term_hit[1] | term_hit[2] | term_hit[3], 1'b0, "R1 R4 masks cleared");
      clr_in();

      // R2 R3 R6 R10: sweep every direct condition bit
      wr(4, 32'h1);
      for (int b = 0; b < 28; b++) begin
         if (b >= 16 && b < 20) continue;
         wr(0, 32'd1 << b);
         fold_in = '1;
         logic_in = '1;
         set_direct(b, 1'b0);
         step();
         chk(term_hit[0], 1'b0, $sformatf("R2 bit%0d others high", b));
         chk(trig_req, 1'b0, $sformatf("R2 no trig bit%0d", b));
         set_direct(b, 1'b1);
         step();
         chk(term_hit[0], 1'b1, $sformatf("R3 bit%0d hit", b));
         chk(trig_req, 1'b1, $sformatf("R6 rise bit%0d", b));
         step();
         chk(term_hit[0], 1'b1, $sformatf("R3 bit%0d held", b));
         chk(trig_req, 1'b0, $sformatf("R6 no retrigger bit%0d", b));
         clr_in();
         step();
         chk(term_hit[0], 1'b0, $sformatf("R3 bit%0d cleared", b));
      end

      // R3 two-condition AND: fold s0 l1 AND logic 1
      wr(0, (32'd1 << 1) | (32'd1 << 21));
      fold_in[1] = 1'b1;
      step();
      chk(term_hit[0], 1'b0, "R3 AND only fold");
      clr_in(); logic_in[1] = 1'b1;
      step();
      chk(term_hit[0], 1'b0, "R3 AND only logic");
      fold_in[1] = 1'b1;
      step();
      chk(term_hit[0], 1'b1, "R3 AND both");
      chk(trig_req, 1'b1, "R3 AND trig");
      clr_in(); step();

      // R4 zero mask term selected
      wr(1, 32'd0);
      wr(4, 32'h2);
      fold_in = '1; logic_in = '1;
      step(); step();
      chk(term_hit[1], 1'b0, "R4 zero mask never fires");
      chk(trig_req, 1'b0, "R4 zero mask no trig");
      clr_in(); step();

      // R5 unselected term shows but does not trigger; R10 term 2 address
      wr(2, 32'd1 << 5);
      wr(4, 32'h1);
      fold_in[5] = 1'b1;
      step();
      chk(term_hit[2], 1'b1, "R5 R10 term2 hit");
      chk(trig_req, 1'b0, "R5 unselected term no trig");
      clr_in(); step();
      wr(4, 32'h4);
      fold_in[5] = 1'b1;
      step();
      chk(trig_req, 1'b1, "R5 selected term2 trig");
      clr_in(); step();

      // R7 enable low blocks the rising edge
      enable = 1'b0;
      fold_in[5] = 1'b1;
      step();
      chk(term_hit[2], 1'b1, "R7 term still hits");
      chk(trig_req, 1'b0, "R7 enable low blocks");
      enable = 1'b1;
      clr_in(); step();
      wr(2, 32'd0);

      // R8 R9 retiming stages
      for (int k = 0; k < 8; k++) begin
         run_align(k, 0, 1, 1'b0);
         run_align(k, 1, 2, 1'b0);
         run_align(k, 3, 1, 1'b0);
      end
      run_align(0, 2, 3, 1'b1);
      run_align(5, 2, 3, 1'b1);
      run_align(2, 1, 0, 1'b0);
      run_align(6, 0, 0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule